// File: doc/BRIEF.md
# Bit-Plane Range Search Engine

The block keeps a small store of words held as bit planes: plane `j` carries bit `j` of every word side by side. A search finds every stored word `K` with `lo_bound <= K <= hi_bound`. It takes one plane per clock and tests all words against the bound bit at once. There are two passes, each going from the top plane down to plane 0. The first pass keeps two masks, "proven above" and "still alive", in place of a carry chain. The words that survive it become the starting alive set of the second pass. The second pass is the mirror image of the first and tests against the upper bound. Intermediate masks stay in registers. The store is only written through the load port.

Words enter through a valid/ready load port. `ld_ready` is high whenever no search is running. A load that is offered while `ld_ready` is low is not taken, and the source must hold it until `ld_ready` returns. A search is started by a one-cycle `start` while the block is idle. `start` while busy is ignored. The bounds and the word-enable mask are captured at the start. The result appears on `match` together with a one-cycle `done` pulse and holds until the next result.

Top module: `bls_range_search`

## Requirements
- R1: A load handshake (`ld_valid` and `ld_ready` high at a rising edge) writes `ld_data` into word `ld_addr`. Every later search sees that value.
- R2: `ld_ready` is low for exactly the cycles in which `busy` is high. A load offered then is not taken, and the store word keeps its earlier value.
- R3: After a search, `match[i]` is 1 exactly when word `i` was enabled and `lo_bound <= K_i <= hi_bound` as unsigned numbers. Words equal to either bound match.
- R4: A word whose bit in `word_en` was 0 at the start never matches, whatever its value.
- R5: When `lo_bound > hi_bound`, the result is all zeros.
- R6: A start taken at edge `e` raises `busy` after `e`. `busy` stays high for 2*BITS cycles. `done` is high for exactly the one cycle after edge `e + 2*BITS`, and `busy` is low in that cycle.
- R7: `start` while `busy` is high has no effect. The running search finishes at its original time with its original result.
- R8: `match` changes only at the edge that raises `done`. At all other times it holds its value.
- R9: After reset, `busy`, `done` and `match` are 0, `ld_ready` is 1, and every stored word is 0.
- R10: The bounds and `word_en` are sampled at the start edge. Changes to them during a search do not affect its result.
- R11: When a load and a start are taken at the same edge, the write applies first, and the search includes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load accepted when high (block idle) |
| ld_addr | input | $clog2(WORDS) | Word index to write |
| ld_data | input | BITS | Word value to write |
| start | input | 1 | Start a search (taken when idle) |
| lo_bound | input | BITS | Inclusive lower bound |
| hi_bound | input | BITS | Inclusive upper bound |
| word_en | input | WORDS | Words taking part in the search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| match | output | WORDS | Words inside the range, held until the next result |

## Verification
Two coincidences matter here. The first is a load and a start taken at the same edge. The bench provokes it by driving both in one cycle, with a new value chosen so that only its written version lies inside the range. The match bit for that word then shows whether the write landed before the first plane was read. The second is a start or a load arriving while a search is running, including in its last cycle. The reference model keeps the original finish time, a store without the offered word, and the result computed from the captured bounds, and the model is compared with the outputs on every clock.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOWER = 2'd1,
    ST_UPPER = 2'd2
  } bls_state_e;
endpackage

// File: rtl/bls_plane_store.sv
module bls_plane_store #(
  parameter int WORDS = 16,
  parameter int BITS  = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IW   = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BITS-1:0]  wr_data,
  input  logic [IW-1:0]    rd_plane,
  output logic [WORDS-1:0] rd_row
);
  logic [WORDS-1:0] plane_q [BITS];

  for (genvar p = 0; p < BITS; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        plane_q[p] <= '0;
      end else if (wr_en) begin
        plane_q[p][wr_addr] <= wr_data[p];
      end
    end
  end

  assign rd_row = plane_q[rd_plane];
endmodule

// File: rtl/bls_pass_unit.sv
module bls_pass_unit #(
  parameter int WORDS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [WORDS-1:0] alive_init,
  input  logic             step,
  input  logic             clr_ahead,
  input  logic             upper,
  input  logic             bnd_bit,
  input  logic [WORDS-1:0] row,
  output logic [WORDS-1:0] alive_next
);
  logic [WORDS-1:0] ahead_q, alive_q;
  logic [WORDS-1:0] row_x, ahead_next;

  // The upper pass is the lower pass with the data inverted.
  assign row_x = upper ? ~row : row;

  always_comb begin
    alive_next = alive_q;
    ahead_next = ahead_q;
    if (step) begin
      if (bnd_bit) alive_next = alive_q & (ahead_q | row_x);
      else         ahead_next = ahead_q | (row_x & alive_q);
    end
    if (clr_ahead) ahead_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ahead_q <= '0;
      alive_q <= '0;
    end else if (init) begin
      ahead_q <= '0;
      alive_q <= alive_init;
    end else begin
      ahead_q <= ahead_next;
      alive_q <= alive_next;
    end
  end
endmodule

// File: rtl/bls_sequencer.sv
module bls_sequencer
  import bls_pkg::*;
#(
  parameter int BITS = 8,
  localparam int IW  = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] lo_bound,
  input  logic [BITS-1:0] hi_bound,
  output logic            init,
  output logic            step,
  output logic            clr_ahead,
  output logic            upper,
  output logic            bnd_bit,
  output logic            last_step,
  output logic [IW-1:0]   plane,
  output logic            busy,
  output logic            done
);
  localparam logic [IW-1:0] TOP = IW'(BITS - 1);

  bls_state_e      state_q;
  logic [IW-1:0]   idx_q;
  logic [BITS-1:0] lo_q, hi_q;
  logic            plane_zero;

  assign plane_zero = (idx_q == '0);
  assign busy       = (state_q != ST_IDLE);
  assign init       = (state_q == ST_IDLE) && start;
  assign step       = busy;
  assign upper      = (state_q == ST_UPPER);
  assign clr_ahead  = (state_q == ST_LOWER) && plane_zero;
  assign last_step  = (state_q == ST_UPPER) && plane_zero;
  assign bnd_bit    = upper ? ~hi_q[idx_q] : lo_q[idx_q];
  assign plane      = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOWER;
          idx_q   <= TOP;
          lo_q    <= lo_bound;
          hi_q    <= hi_bound;
        end
        ST_LOWER: if (plane_zero) begin
          state_q <= ST_UPPER;
          idx_q   <= TOP;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
        ST_UPPER: if (plane_zero) begin
          state_q <= ST_IDLE;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bls_range_search.sv
module bls_range_search #(
  parameter int WORDS = 16,
  parameter int BITS  = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IW   = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [AW-1:0]    ld_addr,
  input  logic [BITS-1:0]  ld_data,
  input  logic             start,
  input  logic [BITS-1:0]  lo_bound,
  input  logic [BITS-1:0]  hi_bound,
  input  logic [WORDS-1:0] word_en,
  output logic             busy,
  output logic             done,
  output logic [WORDS-1:0] match
);
  logic             init, step, clr_ahead, upper, bnd_bit, last_step;
  logic [IW-1:0]    plane;
  logic [WORDS-1:0] row, alive_next;

  assign ld_ready = !busy;

  bls_sequencer #(.BITS(BITS)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lo_bound(lo_bound), .hi_bound(hi_bound),
    .init(init), .step(step), .clr_ahead(clr_ahead), .upper(upper),
    .bnd_bit(bnd_bit), .last_step(last_step), .plane(plane),
    .busy(busy), .done(done)
  );

  bls_plane_store #(.WORDS(WORDS), .BITS(BITS)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_valid && ld_ready), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_plane(plane), .rd_row(row)
  );

  bls_pass_unit #(.WORDS(WORDS)) i_pass (
    .clk(clk), .rst_n(rst_n), .init(init), .alive_init(word_en),
    .step(step), .clr_ahead(clr_ahead), .upper(upper),
    .bnd_bit(bnd_bit), .row(row), .alive_next(alive_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         match <= '0;
    else if (last_step) match <= alive_next;
  end
endmodule

// File: rtl/bls_range_search_chk.sv
module bls_range_search_chk #(
  parameter int WORDS = 16,
  parameter int BITS  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_ready,
  input logic             start,
  input logic [WORDS-1:0] word_en,
  input logic             busy,
  input logic             done,
  input logic [WORDS-1:0] match
);
  logic [15:0]      run_cnt;
  logic [WORDS-1:0] en_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      en_cap  <= '0;
    end else begin
      if (!busy && start) begin
        en_cap  <= word_en;
        run_cnt <= 16'd1;
      end else if (busy) begin
        run_cnt <= run_cnt + 16'd1;
      end
    end
  end

  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_cnt == 16'(2 * BITS + 1)));
  // R7
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(match));
  // R4
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((match & ~en_cap) == '0));
endmodule

bind bls_range_search bls_range_search_chk #(.WORDS(WORDS), .BITS(BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .start(start),
  .word_en(word_en), .busy(busy), .done(done), .match(match)
);

// File: tb/test_bls_range_search.sv
module test_bls_range_search;
  localparam int WORDS = 16;
  localparam int BITS  = 8;
  localparam int AW    = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_valid = 1'b0;
  logic [AW-1:0]    ld_addr = '0;
  logic [BITS-1:0]  ld_data = '0;
  logic             start = 1'b0;
  logic [BITS-1:0]  lo_bound = '0;
  logic [BITS-1:0]  hi_bound = '0;
  logic [WORDS-1:0] word_en = '0;
  logic             ld_ready, busy, done;
  logic [WORDS-1:0] match;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bls_range_search #(.WORDS(WORDS), .BITS(BITS)) i_bls_range_search (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .word_en(word_en),
    .busy(busy), .done(done), .match(match)
  );

  // Behavioural reference model
  int               mem [WORDS];
  int               m_rem;
  bit               m_done;
  logic [WORDS-1:0] m_match, m_pend;

  function automatic logic [WORDS-1:0] range_of(int lo, int hi, logic [WORDS-1:0] en);
    logic [WORDS-1:0] r = '0;
    for (int i = 0; i < WORDS; i++)
      r[i] = en[i] && (mem[i] >= lo) && (mem[i] <= hi);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] = 0;
      m_rem = 0; m_done = 0; m_match = '0; m_pend = '0;
    end else begin
      bit idle;
      idle = (m_rem == 0);
      if (ld_valid && idle) mem[ld_addr] = int'(ld_data);
      m_done = 0;
      if (!idle) begin
        m_rem--;
        if (m_rem == 0) begin m_done = 1; m_match = m_pend; end
      end else if (start) begin
        m_rem  = 2 * BITS;
        m_pend = range_of(int'(lo_bound), int'(hi_bound), word_en);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 busy", 32'(busy), 32'(m_rem != 0));
      chk("R6 done", 32'(done), 32'(m_done));
      chk("R2 ld_ready", 32'(ld_ready), 32'(m_rem == 0));
      chk("R3/R8 match", 32'(match), 32'(m_match));
    end
  end

  task automatic load(int a, int d);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_addr = AW'(a); ld_data = BITS'(d);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic search(int lo, int hi, logic [WORDS-1:0] en, string tag);
    logic [WORDS-1:0] exp;
    @(negedge clk);
    lo_bound = BITS'(lo); hi_bound = BITS'(hi); word_en = en;
    exp = range_of(lo, hi, en);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(tag, 32'(match), 32'(exp));
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", 32'(busy), 0);
    chk("R9 done", 32'(done), 0);
    chk("R9 match", 32'(match), 0);
    chk("R9 ld_ready", 32'(ld_ready), 1);
    search(0, 0, '1, "R9 store zero");

    // R1 load a pattern with duplicates and bound values
    for (int i = 0; i < WORDS; i++) load(i, (i * 37 + 11) % 256);
    load(3, 50); load(7, 50); load(9, 120); load(12, 0); load(13, 255);
    search(50, 120, '1, "R3 inclusive bounds");
    search(0, 255, '1, "R1 full range");
    search(50, 50, '1, "R3 single value");
    search(0, 0, '1, "R3 zero bound");
    search(255, 255, '1, "R3 max bound");
    search(121, 49, '1, "R5 empty range");
    search(51, 50, '1, "R5 adjacent crossed");
    search(0, 255, 16'h0F0F, "R4 mask partial");
    search(50, 120, 16'h0000, "R4 mask none");

    // R10 + R7 + R2: disturb inputs during a run
    @(negedge clk);
    lo_bound = 8'd10; hi_bound = 8'd200; word_en = 16'hFFFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    lo_bound = 8'd0; hi_bound = 8'd5; word_en = 16'h0001; start = 1'b1;
    ld_valid = 1'b1; ld_addr = 4'd5; ld_data = 8'd3;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    ld_valid = 1'b0;
    chk("R10/R7 captured bounds", 32'(match), 32'(range_of(10, 200, 16'hFFFF)));
    search(0, 255, 16'h0020, "R2 word5 kept");
    chk("R2 word5 value", 32'(mem[5]), 32'((5 * 37 + 11) % 256));

    // R11 load and start at the same edge
    @(negedge clk);
    lo_bound = 8'd200; hi_bound = 8'd210; word_en = '1;
    ld_valid = 1'b1; ld_addr = 4'd2; ld_data = 8'd205; start = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 same-edge load", 32'(match[2]), 1);

    for (int k = 0; k < 6; k++)
      search((k * 41) % 256, (k * 41 + 90) % 256, 16'hFFFF >> k, "R3 sweep");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule